// File: doc/BRIEF.md
# Codec Timing Generator

This block derives every timing signal that a converter's serial port and filter section need from a single master clock. A fixed divide-by-four produces the shift clock. A programmable divider produces a filter-clock enable once every 2·A master cycles. A second programmable divider counts those filter enables and marks a frame once every B of them. A frame opens an active-low frame-sync window lasting sixteen shift-clock periods, so the sampling rate is the master clock divided by 2·A·B.

After reset the block waits a fixed startup interval, 648 master cycles by default, before it runs. The first frame is forced at the end of that interval. Frame-sync edges are aligned to shift-clock rising edges, so a receiver can sample the pin cleanly on the falling edge. All outputs are registered levels or single-cycle enables in the master-clock domain. No clock is gated. The divider values are expected to be quasi-static, and A·B must be at least 34 so that a window plus its alignment fits inside one frame.

Top module: `codec_timing_gen`

## Requirements
- R1: `shift_clk` is a square wave of four master cycles that starts low at reset release. Counting active edges n = 1, 2, … from the third rising edge after `rst_n` rises, `shift_clk` is high after edge n exactly when n mod 4 is 2 or 3.
- R2: `fclk_en` is high for exactly one master cycle per filter period. The filter period is 2·A master cycles. The first pulse ends 2·A active edges after the startup edge.
- R3: Each `fsync_n` low window lasts exactly 64 master cycles, which is 16 shift-clock periods. `fsync_n` falls and rises only on edges where `shift_clk` rises.
- R4: Successive `fsync_n` falling edges are 2·A·B master cycles apart whenever 2·A·B is a multiple of four.
- R5: Before the startup edge (active edge 648 by default), `fsync_n` stays high and `fclk_en` stays low. The first `fsync_n` fall occurs on the first shift-clock rising edge at or after that edge, which is active edge 650.
- R6: A change of A or B takes effect only when the counter that uses it reaches terminal count. The filter period in progress when A changes completes at its old length.
- R7: A value of zero on `div_a` or `div_b` acts as one.
- R8: `rst_n` low forces `shift_clk` = 0, `fclk_en` = 0 and `fsync_n` = 1 at once. These values hold through the two master edges that the release synchronizer takes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| div_a | input | 8 | Filter divider value A (zero acts as one) |
| div_b | input | 8 | Frame divider value B (zero acts as one) |
| shift_clk | output | 1 | Shift clock, master clock divided by four |
| fclk_en | output | 1 | Single-cycle filter-clock enable every 2·A cycles |
| fsync_n | output | 1 | Active-low frame-sync window, 16 shift periods long |

## Verification
On every cycle, the assertions check the local rules. `fsync_n` changes only when `shift_clk` rises, `shift_clk` stays high for at least two cycles after it rises, filter enables are never back to back, and nothing fires before the startup interval ends. Other properties need a frame history and can only be shown by the bench scenarios. These are the exact position of the first frame after reset, the spacing of frame falls for several A and B values, zero values acting as one, the completion of a filter period at its old length when A changes, and recovery after a reset in the middle of a window.

// File: rtl/ctg_pkg.sv
package ctg_pkg;
  localparam int DIV_W          = 8;    // width of divider values A and B
  localparam int STARTUP_CYCLES = 648;  // master cycles before the first frame
  localparam int SHIFT_LOG2     = 2;    // shift clock = master / 2**SHIFT_LOG2
  localparam int WINDOW_SHIFTS  = 16;   // frame-sync length in shift periods

  // zero divider values behave as one
  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] v);
    return (v == '0) ? DIV_W'(1) : v;
  endfunction
endpackage

// File: rtl/ctg_reset_sync.sv
module ctg_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      srst_n  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      srst_n  <= stage_q;
    end
  end
endmodule

// File: rtl/ctg_startup.sv
module ctg_startup #(
  parameter int COUNT = 648
) (
  input  logic clk,
  input  logic rst_n,
  output logic go,
  output logic running
);
  localparam int CW = (COUNT > 2) ? $clog2(COUNT) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_d;

  assign go = !running && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    run_d = running;
    if (!running) begin
      if (cnt_q == '0) run_d = 1'b1;
      else             cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CW'(COUNT - 1);
      running <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      running <= run_d;
    end
  end
endmodule

// File: rtl/ctg_shift_gen.sv
module ctg_shift_gen #(
  parameter int LOG2 = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic shift_clk,
  output logic rise_en
);
  logic [LOG2-1:0] ph_q, ph_d;

  // rising edge of shift_clk happens on the edge that leaves this phase
  localparam logic [LOG2-1:0] PRE_RISE = LOG2'((1 << (LOG2 - 1)) - 1);

  assign shift_clk = ph_q[LOG2-1];
  assign rise_en   = (ph_q == PRE_RISE);

  always_comb ph_d = ph_q + LOG2'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end
endmodule

// File: rtl/ctg_prog_div.sv
module ctg_prog_div
  import ctg_pkg::*;
#(
  parameter int VAL_W = DIV_W,
  parameter int SCALE_LOG2 = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             en,
  input  logic [VAL_W-1:0] val,
  output logic             tick
);
  localparam int CNT_W = VAL_W + SCALE_LOG2;

  logic [CNT_W-1:0] cnt_q, cnt_d, reload;
  logic [VAL_W-1:0] v_eff;

  always_comb begin
    v_eff  = (val == '0) ? VAL_W'(1) : val;
    reload = (CNT_W'(v_eff) << SCALE_LOG2) - CNT_W'(1);
  end

  assign tick = en && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (start)     cnt_d = reload;
    else if (en) begin
      if (cnt_q == '0) cnt_d = reload;   // new value only at terminal count
      else             cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: a period is never shorter than two enables
  a_r2_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && SCALE_LOG2 > 0) |=> !tick);
endmodule

// File: rtl/ctg_fsync.sv
module ctg_fsync #(
  parameter int WINDOW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_en,
  input  logic frame_evt,
  output logic fsync_n
);
  localparam int BW = $clog2(WINDOW);

  logic [BW-1:0] bits_q, bits_d;
  logic          pend_q, pend_d, fs_d;

  always_comb begin
    bits_d = bits_q;
    pend_d = pend_q || frame_evt;
    fs_d   = fsync_n;
    if (rise_en) begin
      if (!fsync_n) begin
        if (bits_q == BW'(WINDOW - 1)) fs_d = 1'b1;
        else                           bits_d = bits_q + BW'(1);
      end else if (pend_q || frame_evt) begin
        fs_d   = 1'b0;
        bits_d = '0;
        pend_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q  <= '0;
      pend_q  <= 1'b0;
      fsync_n <= 1'b1;
    end else begin
      bits_q  <= bits_d;
      pend_q  <= pend_d;
      fsync_n <= fs_d;
    end
  end

  // R3: the window only opens on a pending or current frame
  a_r3_open_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fsync_n) |-> $past(pend_q || frame_evt));
endmodule

// File: rtl/codec_timing_gen.sv
module codec_timing_gen
  import ctg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_a,
  input  logic [DIV_W-1:0] div_b,
  output logic             shift_clk,
  output logic             fclk_en,
  output logic             fsync_n
);
  logic srst_n, go, running, rise_en, frame_tick, frame_evt;

  ctg_reset_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  ctg_startup #(.COUNT(STARTUP_CYCLES)) u_start (
    .clk     (clk),
    .rst_n   (srst_n),
    .go      (go),
    .running (running)
  );

  ctg_shift_gen #(.LOG2(SHIFT_LOG2)) u_shift (
    .clk       (clk),
    .rst_n     (srst_n),
    .shift_clk (shift_clk),
    .rise_en   (rise_en)
  );

  // filter clock: 2*A master cycles
  ctg_prog_div #(.VAL_W(DIV_W), .SCALE_LOG2(1)) u_fdiv (
    .clk   (clk),
    .rst_n (srst_n),
    .start (go),
    .en    (running),
    .val   (div_a),
    .tick  (fclk_en)
  );

  // frame: B filter clocks
  ctg_prog_div #(.VAL_W(DIV_W), .SCALE_LOG2(0)) u_bdiv (
    .clk   (clk),
    .rst_n (srst_n),
    .start (go),
    .en    (fclk_en),
    .val   (div_b),
    .tick  (frame_tick)
  );

  assign frame_evt = go || frame_tick;

  ctg_fsync #(.WINDOW(WINDOW_SHIFTS)) u_fs (
    .clk       (clk),
    .rst_n     (srst_n),
    .rise_en   (rise_en),
    .frame_evt (frame_evt),
    .fsync_n   (fsync_n)
  );

  // R3: frame-sync edges sit on shift-clock rising edges
  a_r3_edge_aligned: assert property (@(posedge clk) disable iff (!srst_n)
    !$stable(fsync_n) |-> $rose(shift_clk));

  // R1: shift clock high phase lasts at least two cycles
  a_r1_high_phase: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(shift_clk) |=> shift_clk);

  // R5: nothing happens before the startup interval ends
  a_r5_quiet_startup: assert property (@(posedge clk) disable iff (!srst_n)
    !running |-> (fsync_n && !fclk_en));

  // R2: filter enables only while running
  a_r2_fclk_running: assert property (@(posedge clk) disable iff (!srst_n)
    fclk_en |-> running);
endmodule

// File: tb/codec_timing_gen_test.sv
module codec_timing_gen_test;
  localparam int STARTUP = 648;
  localparam int WIN     = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_a = 8'd3;
  logic [7:0] div_b = 8'd12;
  logic       shift_clk, fclk_en, fsync_n;

  always #4 clk = ~clk;

  codec_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .div_a(div_a), .div_b(div_b),
    .shift_clk(shift_clk), .fclk_en(fclk_en), .fsync_n(fsync_n)
  );

  int compared = 0, mismatched = 0, cyc = 0;
  string tag = "R5";

  // behavioural reference
  int  m_s1 = 0, m_s2 = 0, n = 0, next_f = 0, left = 0, wend = 0;
  bit  pend = 0, low = 0;
  int  falls[$], widths[$], fts[$];
  int  last_fall = 0;
  bit  prev_fs = 1;

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; n = 0; next_f = 0; left = 0;
      pend = 0; low = 0; wend = 0;
    end else begin
      if (m_s2 == 1) begin
        bit frame;
        n++;
        frame = 0;
        if (n == STARTUP) begin
          next_f = n + 2 * eff(div_a); left = eff(div_b); frame = 1;
        end else if (n > STARTUP && n == next_f) begin
          next_f = n + 2 * eff(div_a);
          left--;
          if (left == 0) begin frame = 1; left = eff(div_b); end
        end
        if (frame) pend = 1;
        if (n % 4 == 2) begin
          if (low) begin
            if (n == wend) low = 0;
          end else if (pend) begin
            low = 1; wend = n + WIN; pend = 0;
          end
        end
      end
      m_s2 = m_s1; m_s1 = 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at n=%0d", req, act, exp, n);
    end
  endtask

  // every-cycle comparison, sampled at the falling edge
  always @(negedge clk) begin
    bit e_sh, e_fc, e_fs;
    e_sh = (n % 4) >= 2;
    e_fc = (n >= STARTUP) && (n + 1 == next_f);
    e_fs = !low;
    chk({"R1 shift_clk ", tag}, int'(shift_clk), int'(e_sh));
    chk({"R2 fclk_en ",   tag}, int'(fclk_en),   int'(e_fc));
    chk({"R3 fsync_n ",   tag}, int'(fsync_n),   int'(e_fs));
    if (prev_fs && !fsync_n) begin falls.push_back(n); last_fall = n; end
    if (!prev_fs && fsync_n) widths.push_back(n - last_fall);
    if (fclk_en) fts.push_back(n);
    prev_fs = fsync_n;
  end

  task automatic summary_and_end();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL R5 watchdog: actual %0d cycles expected fewer than 150000", cyc);
      summary_and_end();
    end
  end

  task automatic wait_falls(input int k);
    int start = falls.size();
    while (falls.size() < start + k) @(negedge clk);
  endtask

  initial begin
    int t0;
    // R8: reset values while held
    repeat (5) @(negedge clk);
    chk("R8 reset shift_clk", int'(shift_clk), 0);
    chk("R8 reset fclk_en",   int'(fclk_en),   0);
    chk("R8 reset fsync_n",   int'(fsync_n),   1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 sync release shift_clk", int'(shift_clk), 0);

    // R5, R4, R3 with A=3 B=12: period 72
    wait_falls(3);
    chk("R5 first fall edge", falls[0], 650);
    chk("R4 spacing A3 B12", falls[1] - falls[0], 72);
    chk("R4 spacing A3 B12 again", falls[2] - falls[1], 72);
    while (widths.size() < 1) @(negedge clk);
    chk("R3 window length", widths[0], WIN);

    // R6: A change mid filter period
    tag = "R6";
    @(negedge clk);
    while (!fclk_en) @(negedge clk);
    t0 = n;
    @(negedge clk);
    fts.delete();
    div_a = 8'd5;
    while (fts.size() < 2) @(negedge clk);
    chk("R6 old filter period completes", fts[0] - t0, 6);
    chk("R6 new filter period", fts[1] - fts[0], 10);
    div_b = 8'd20;
    wait_falls(4);
    chk("R4 R6 spacing A5 B20", falls[falls.size()-1] - falls[falls.size()-2], 200);

    // R7: zero acts as one
    tag = "R7";
    div_a = 8'd0; div_b = 8'd40;
    wait_falls(4);
    chk("R7 A zero spacing", falls[falls.size()-1] - falls[falls.size()-2], 80);
    div_a = 8'd40; div_b = 8'd0;
    wait_falls(4);
    chk("R7 B zero spacing", falls[falls.size()-1] - falls[falls.size()-2], 80);

    // R8: asynchronous reset in the middle of a window
    tag = "R8";
    while (fsync_n) @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    chk("R8 async fsync_n", int'(fsync_n), 1);
    chk("R8 async shift_clk", int'(shift_clk), 0);
    chk("R8 async fclk_en", int'(fclk_en), 0);
    div_a = 8'd3; div_b = 8'd12;
    repeat (3) @(negedge clk);
    falls.delete(); widths.delete();
    rst_n = 1'b1;
    tag = "R5";
    wait_falls(2);
    chk("R5 first fall after reset", falls[0], 650);
    chk("R4 spacing after reset", falls[1] - falls[0], 72);

    repeat (10) @(negedge clk);
    summary_and_end();
  end
endmodule